// File: doc/BRIEF.md
# Block-Transfer Launch and Status Tracker

This block is the control front end of a 2D block-transfer engine. A host writes a master register set over a simple register port. The set holds a source address, a destination address, a raster mode word, a line-width select and a pixel-depth select. A write to the mode register is itself the launch command. A launched operation waits in the master set, with a pending flag raised, until the data pipeline is idle. In one cycle the master set is then copied into a working set, a single-cycle start pulse goes to the pipeline, and the pipeline-busy flag rises.

Busy is reported in two parts. Pipeline-busy follows only the data pipeline, from start until it signals done. A separate counter tracks memory requests that have not yet been acknowledged. Overall blit-busy is pipeline-busy OR a nonzero count, so it stays set after the pipeline finishes, until the memory side has answered every request. The host must not reload the master set while pending is set. If it does, the write goes through and the waiting operation is corrupted. The block does not stall the host.

Top module: `blit_ctrl`

## Requirements
- R1: After synchronous reset the status word, the working set, the start pulse and the outstanding count are all zero.
- R2: A host write to the mode register (index 3) sets pending in the next cycle. Writes to source (0), destination (1) and config (2) never launch an operation.
- R3: When pending is set and the pipeline is idle, the next cycle shows a one-cycle start pulse, working set equal to the master set, pending clear (unless another mode write was made in the transfer cycle) and pipeline-busy set. A launch into an idle block therefore shows pending for exactly one cycle.
- R4: While pipeline-busy is set, pending stays set. The transfer happens in the cycle after done clears pipeline-busy.
- R5: A master write made while pending is set overwrites the waiting values, and the transfer carries the latest values. The working outputs change only at a transfer.
- R6: Pipeline-busy clears in the cycle after done. Done is ignored when the pipeline is idle. Blit-busy equals pipeline-busy OR outstanding count nonzero.
- R7: The outstanding count rises on a request without an acknowledge and falls on an acknowledge without a request. It holds when both or neither are present, ignores an acknowledge at zero, and saturates at its maximum.
- R8: The status word (config register, index 2) reads blit-busy at bit 0, pipeline-busy at bit 1, pending at bit 2, 16-bpp select at bit 8 and wide-line select at bit 9, with all other bits zero. A write to it changes only bits 8 and 9.
- R9: The working pitch is 2048 bytes when the captured wide select is 1 and 1024 when it is 0. The working 16-bpp output equals the captured depth select.
- R10: The mode bits [1:0] of the working set choose the source. 00 selects the all-ones source. 01 selects a frame-buffer read staged in buffer 0. 10 selects buffer 0 and 11 selects buffer 1. The buffer-index output is 1 only for 11.
- R11: Read data is registered: the value for a read index appears one cycle after that index is presented. Indexes 0, 1 and 3 return the zero-extended master values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Write register index |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read register index |
| rd_data | output | DW | Registered read data |
| pipe_start | output | 1 | One-cycle start pulse to the data pipeline |
| pipe_done | input | 1 | Pipeline finished the current operation |
| pipe_src_addr | output | PW | Working source address |
| pipe_dst_addr | output | PW | Working destination address |
| pipe_mode | output | MODE_W | Working raster mode word |
| pipe_src_ones | output | 1 | Source is all ones |
| pipe_src_fb | output | 1 | Source read from frame buffer |
| pipe_src_buf | output | 1 | Buffer index used for source |
| pipe_pitch | output | 12 | Line pitch in bytes |
| pipe_bpp16 | output | 1 | 16 bits per pixel when set |
| mem_req | input | 1 | Memory request issued |
| mem_ack | input | 1 | Memory request served |
| mem_outstanding | output | CNT_W | Unserved request count |
| sts_pending | output | 1 | Operation waiting in master set |
| sts_pipe_busy | output | 1 | Data pipeline active |
| sts_blit_busy | output | 1 | Pipeline active or requests unserved |

## Verification
The bench builds the block with CNT_W = 3 and PW = 16. A request burst of nine cycles therefore hits the saturation limit of seven, and a long acknowledge run drives the count through zero into ignored acknowledges. The 16-bit addresses keep every overwrite-while-pending value visible in full on the working outputs. Directed phases cover back-to-back launches, an overwrite while pending and acknowledges after done. Random traffic mixes done pulses in idle cycles, simultaneous request and acknowledge, and launches in the transfer cycle.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    REG_SRC  = 2'd0,
    REG_DST  = 2'd1,
    REG_CFG  = 2'd2,
    REG_MODE = 2'd3
  } blit_reg_e;

  typedef enum logic [1:0] {
    SRC_ONES = 2'b00,
    SRC_FB   = 2'b01,
    SRC_BUF0 = 2'b10,
    SRC_BUF1 = 2'b11
  } blit_src_e;

  localparam int STS_BBUSY = 0;
  localparam int STS_PBUSY = 1;
  localparam int STS_PEND  = 2;
  localparam int STS_DEEP  = 8;
  localparam int STS_WIDE  = 9;

  localparam int PITCH_W = 12;
  localparam logic [PITCH_W-1:0] PITCH_NARROW = 12'd1024;
  localparam logic [PITCH_W-1:0] PITCH_WIDE   = 12'd2048;
endpackage

// File: rtl/blit_host_regs.sv
module blit_host_regs
  import blit_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PW     = 32,
  parameter int MODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              flag_pending,
  input  logic              flag_pbusy,
  input  logic              flag_bbusy,
  output logic [PW-1:0]     m_src,
  output logic [PW-1:0]     m_dst,
  output logic [MODE_W-1:0] m_mode,
  output logic              m_wide,
  output logic              m_deep,
  output logic              launch,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] status_word;
  logic [DW-1:0] rd_next;

  assign launch = wr_en && (wr_addr == REG_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_src  <= '0;
      m_dst  <= '0;
      m_mode <= '0;
      m_wide <= 1'b0;
      m_deep <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_SRC:  m_src  <= wr_data[PW-1:0];
        REG_DST:  m_dst  <= wr_data[PW-1:0];
        REG_CFG: begin
          m_wide <= wr_data[STS_WIDE];
          m_deep <= wr_data[STS_DEEP];
        end
        default:  m_mode <= wr_data[MODE_W-1:0];
      endcase
    end
  end

  always_comb begin
    status_word            = '0;
    status_word[STS_BBUSY] = flag_bbusy;
    status_word[STS_PBUSY] = flag_pbusy;
    status_word[STS_PEND]  = flag_pending;
    status_word[STS_DEEP]  = m_deep;
    status_word[STS_WIDE]  = m_wide;
  end

  always_comb begin
    case (rd_addr)
      REG_SRC: rd_next = DW'(m_src);
      REG_DST: rd_next = DW'(m_dst);
      REG_CFG: rd_next = status_word;
      default: rd_next = DW'(m_mode);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/blit_launch.sv
module blit_launch #(
  parameter int SET_W = 82
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             pipe_done,
  input  logic [SET_W-1:0] master_set,
  output logic             pending,
  output logic             pbusy,
  output logic             start,
  output logic [SET_W-1:0] work_set
);
  logic transfer;

  assign transfer = pending && !pbusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      pbusy    <= 1'b0;
      start    <= 1'b0;
      work_set <= '0;
    end else begin
      start <= transfer;
      if (transfer) work_set <= master_set;
      if (launch)        pending <= 1'b1;
      else if (transfer) pending <= 1'b0;
      if (transfer)       pbusy <= 1'b1;
      else if (pipe_done) pbusy <= 1'b0;
    end
  end
endmodule

// File: rtl/blit_req_counter.sv
module blit_req_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             nonzero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({req, ack})
        2'b10:   if (count != CNT_MAX) count <= count + 1'b1;
        2'b01:   if (count != '0)      count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign nonzero = (count != '0);
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PW     = 32,
  parameter int MODE_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [1:0]                rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic                      pipe_start,
  input  logic                      pipe_done,
  output logic [PW-1:0]             pipe_src_addr,
  output logic [PW-1:0]             pipe_dst_addr,
  output logic [MODE_W-1:0]         pipe_mode,
  output logic                      pipe_src_ones,
  output logic                      pipe_src_fb,
  output logic                      pipe_src_buf,
  output logic [blit_pkg::PITCH_W-1:0] pipe_pitch,
  output logic                      pipe_bpp16,
  input  logic                      mem_req,
  input  logic                      mem_ack,
  output logic [CNT_W-1:0]          mem_outstanding,
  output logic                      sts_pending,
  output logic                      sts_pipe_busy,
  output logic                      sts_blit_busy
);
  localparam int SET_W = 2 + MODE_W + 2 * PW;

  logic [PW-1:0]     m_src, m_dst;
  logic [MODE_W-1:0] m_mode;
  logic              m_wide, m_deep;
  logic              launch;
  logic              cnt_nz;
  logic [SET_W-1:0]  master_set, work_set;
  logic              w_wide, w_deep;
  blit_src_e         w_sel;

  blit_host_regs #(.DW(DW), .PW(PW), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .flag_pending(sts_pending), .flag_pbusy(sts_pipe_busy), .flag_bbusy(sts_blit_busy),
    .m_src(m_src), .m_dst(m_dst), .m_mode(m_mode), .m_wide(m_wide), .m_deep(m_deep),
    .launch(launch), .rd_data(rd_data)
  );

  assign master_set = {m_wide, m_deep, m_mode, m_dst, m_src};

  blit_launch #(.SET_W(SET_W)) u_launch (
    .clk(clk), .rst(rst),
    .launch(launch), .pipe_done(pipe_done), .master_set(master_set),
    .pending(sts_pending), .pbusy(sts_pipe_busy), .start(pipe_start),
    .work_set(work_set)
  );

  blit_req_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .req(mem_req), .ack(mem_ack),
    .count(mem_outstanding), .nonzero(cnt_nz)
  );

  assign sts_blit_busy = sts_pipe_busy | cnt_nz;

  assign {w_wide, w_deep, pipe_mode, pipe_dst_addr, pipe_src_addr} = work_set;
  assign w_sel = blit_src_e'(pipe_mode[1:0]);

  assign pipe_src_ones = (w_sel == SRC_ONES);
  assign pipe_src_fb   = (w_sel == SRC_FB);
  assign pipe_src_buf  = (w_sel == SRC_BUF1);
  assign pipe_pitch    = w_wide ? PITCH_WIDE : PITCH_NARROW;
  assign pipe_bpp16    = w_deep;
endmodule

// File: rtl/blit_ctrl_chk.sv
module blit_ctrl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             pipe_start,
  input logic             pipe_done,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [CNT_W-1:0] mem_outstanding,
  input logic             sts_pending,
  input logic             sts_pipe_busy,
  input logic             sts_blit_busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_launch_sets_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3) |=> sts_pending);

  assert_start_needs_idle_pending_R3: assert property (@(posedge clk) disable iff (rst)
    pipe_start |-> $past(sts_pending && !sts_pipe_busy));

  assert_start_sets_pbusy_R3: assert property (@(posedge clk) disable iff (rst)
    pipe_start |-> sts_pipe_busy);

  assert_start_clears_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (pipe_start && !$past(wr_en && wr_addr == 2'd3)) |-> !sts_pending);

  assert_pending_holds_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (sts_pending && sts_pipe_busy && !pipe_done) |=> sts_pending);

  assert_pbusy_implies_bbusy_R6: assert property (@(posedge clk) disable iff (rst)
    sts_pipe_busy |-> sts_blit_busy);

  assert_outstanding_implies_bbusy_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_outstanding != '0) |-> sts_blit_busy);

  assert_idle_not_bbusy_R6: assert property (@(posedge clk) disable iff (rst)
    (!sts_pipe_busy && mem_outstanding == '0) |-> !sts_blit_busy);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_outstanding == CNT_MAX && mem_req && !mem_ack) |=> mem_outstanding == CNT_MAX);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_outstanding == '0 && mem_ack && !mem_req) |=> mem_outstanding == '0);
endmodule

bind blit_ctrl blit_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .pipe_start(pipe_start), .pipe_done(pipe_done),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_outstanding(mem_outstanding),
  .sts_pending(sts_pending), .sts_pipe_busy(sts_pipe_busy), .sts_blit_busy(sts_blit_busy)
);

// File: tb/tb_blit_ctrl.sv
module tb_blit_ctrl;
  localparam int CLK_P  = 10;
  localparam int DW     = 32;
  localparam int PW     = 16;
  localparam int MODE_W = 16;
  localparam int CNT_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, pipe_done = 1'b0, mem_req = 1'b0, mem_ack = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic pipe_start, pipe_src_ones, pipe_src_fb, pipe_src_buf, pipe_bpp16;
  logic [PW-1:0] pipe_src_addr, pipe_dst_addr;
  logic [MODE_W-1:0] pipe_mode;
  logic [11:0] pipe_pitch;
  logic [CNT_W-1:0] mem_outstanding;
  logic sts_pending, sts_pipe_busy, sts_blit_busy;

  int n_checks = 0, n_fail = 0;

  // bench reference state
  logic [PW-1:0] m_src = '0, m_dst = '0, w_src = '0, w_dst = '0;
  logic [MODE_W-1:0] m_mode = '0, w_mode = '0;
  logic m_wide = 0, m_deep = 0, w_wide = 0, w_deep = 0;
  logic e_pend = 0, e_pb = 0, e_start = 0, e_rd_sts = 0;
  int e_cnt = 0;
  logic [DW-1:0] e_rd = '0;

  blit_ctrl #(.DW(DW), .PW(PW), .MODE_W(MODE_W), .CNT_W(CNT_W)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] f_status();
    logic [DW-1:0] s = '0;
    s[0] = e_pb || (e_cnt != 0);
    s[1] = e_pb;
    s[2] = e_pend;
    s[8] = m_deep;
    s[9] = m_wide;
    return s;
  endfunction

  function automatic logic [DW-1:0] f_read(input logic [1:0] a);
    case (a)
      2'd0: return DW'(m_src);
      2'd1: return DW'(m_dst);
      2'd2: return f_status();
      default: return DW'(m_mode);
    endcase
  endfunction

  function automatic logic [11:0] f_pitch(input logic wide);
    return wide ? 12'd2048 : 12'd1024;
  endfunction

  task automatic compare();
    chk(sts_pending === e_pend, "R2/R4 pending", 32'(sts_pending), 32'(e_pend));
    chk(sts_pipe_busy === e_pb, "R6 pipe_busy", 32'(sts_pipe_busy), 32'(e_pb));
    chk(sts_blit_busy === (e_pb || e_cnt != 0), "R6 blit_busy", 32'(sts_blit_busy), 32'(e_pb || e_cnt != 0));
    chk(pipe_start === e_start, "R3 start", 32'(pipe_start), 32'(e_start));
    chk(pipe_src_addr === w_src, "R5 work src", 32'(pipe_src_addr), 32'(w_src));
    chk(pipe_dst_addr === w_dst, "R5 work dst", 32'(pipe_dst_addr), 32'(w_dst));
    chk(pipe_mode === w_mode, "R5 work mode", 32'(pipe_mode), 32'(w_mode));
    chk(pipe_pitch === f_pitch(w_wide), "R9 pitch", 32'(pipe_pitch), 32'(f_pitch(w_wide)));
    chk(pipe_bpp16 === w_deep, "R9 bpp16", 32'(pipe_bpp16), 32'(w_deep));
    chk({pipe_src_ones, pipe_src_fb, pipe_src_buf} ===
        {w_mode[1:0] == 2'b00, w_mode[1:0] == 2'b01, w_mode[1:0] == 2'b11},
        "R10 src decode", 32'({pipe_src_ones, pipe_src_fb, pipe_src_buf}),
        32'({w_mode[1:0] == 2'b00, w_mode[1:0] == 2'b01, w_mode[1:0] == 2'b11}));
    chk(int'(mem_outstanding) == e_cnt, "R7 outstanding", 32'(mem_outstanding), 32'(e_cnt));
    chk(rd_data === e_rd, e_rd_sts ? "R8 status read" : "R11 reg read", rd_data, e_rd);
  endtask

  task automatic step(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                      input logic [1:0] ra, input logic dn, input logic rq, input logic ak);
    bit tr;
    @(negedge clk);
    compare();
    tr = e_pend && !e_pb;
    e_rd = f_read(ra);
    e_rd_sts = (ra == 2'd2);
    e_start = tr;
    if (tr) begin
      w_src = m_src; w_dst = m_dst; w_mode = m_mode; w_wide = m_wide; w_deep = m_deep;
    end
    if (we) begin
      case (wa)
        2'd0: m_src = wd[PW-1:0];
        2'd1: m_dst = wd[PW-1:0];
        2'd2: begin m_wide = wd[9]; m_deep = wd[8]; end
        default: m_mode = wd[MODE_W-1:0];
      endcase
    end
    if (we && wa == 2'd3) e_pend = 1;
    else if (tr)          e_pend = 0;
    if (tr)      e_pb = 1;
    else if (dn) e_pb = 0;
    if (rq && !ak && e_cnt != CMAX) e_cnt++;
    else if (ak && !rq && e_cnt != 0) e_cnt--;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    pipe_done = dn; mem_req = rq; mem_ack = ak;
  endtask

  task automatic idle(input int n, input logic dn);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, 2'd2, dn, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed at the ports
    chk(sts_pending === 0 && sts_pipe_busy === 0 && sts_blit_busy === 0, "R1 flags",
        32'({sts_pending, sts_pipe_busy, sts_blit_busy}), 0);
    chk(pipe_start === 0 && mem_outstanding === '0, "R1 start/count",
        32'({pipe_start, mem_outstanding}), 0);
    chk(rd_data === '0 && pipe_src_addr === '0 && pipe_mode === '0, "R1 data", rd_data, 0);

    // R9/R10: configure and launch into idle block (R3 one-cycle pending)
    step(1, 2'd0, 32'h0000_1234, 2'd0, 0, 0, 0);
    step(1, 2'd1, 32'h0000_5678, 2'd1, 0, 0, 0);
    step(1, 2'd2, 32'hFFFF_FCFF, 2'd2, 0, 0, 0); // only bits 8,9 stick (R8)
    step(1, 2'd3, 32'h0000_00A1, 2'd2, 0, 0, 0);
    idle(4, 0);
    // R4/R5: back-to-back launch while busy, then overwrite while pending
    step(1, 2'd3, 32'h0000_0B02, 2'd2, 0, 0, 0);
    step(1, 2'd0, 32'h0000_BEEF, 2'd2, 0, 0, 0);
    step(1, 2'd2, 32'h0000_0100, 2'd2, 0, 0, 0);
    step(1, 2'd3, 32'h0000_0C03, 2'd3, 0, 0, 0);
    idle(2, 0);
    step(0, 2'd0, '0, 2'd2, 1, 1, 0);
    idle(3, 0);
    // R7: saturating burst, done before acks, acks past zero
    for (int i = 0; i < 9; i++) step(0, 2'd0, '0, 2'd2, 0, 1, 0);
    step(0, 2'd0, '0, 2'd2, 1, 1, 1);
    idle(2, 0);
    for (int i = 0; i < 10; i++) step(0, 2'd0, '0, 2'd2, 0, 0, 1);
    idle(2, 1); // R6: done while idle is ignored

    for (int i = 0; i < 4000; i++) begin
      logic we, dn;
      we = ($urandom % 4) == 0;
      dn = (e_pb && ($urandom % 3) == 0) || (($urandom % 16) == 0);
      step(we, 2'($urandom), $urandom, 2'($urandom), dn, 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    compare();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule